// File: doc/BRIEF.md
# Single-Cycle Integer Core Control Decoder

This block turns one 32-bit base-integer instruction word into the full set of select and enable lines that steer a single-cycle datapath. It looks at the major opcode, the three-bit minor function code and bit 30 of the word. From these it picks the next-PC source, the sources of both ALU operands, the ALU function, whether the register file is written, where the write-back value comes from, and whether data memory is accessed and written.

It is purely combinational and holds no state. A one-bit taken flag comes from the branch comparator elsewhere in the datapath. It only matters for conditional branches, where it decides whether the next PC is the ALU-computed target. Immediate assembly, the ALU and the memories sit outside this block.

Internally an opcode classifier reduces the seven opcode bits to one of ten named classes: nine known classes plus an unrecognised class. Two further stages derive the ALU function and the routing controls from that class. There are no states or transitions. The class enumeration takes the place a state encoding would hold in a sequential block.

Top module: `rv_ctl_decoder`

## Requirements
- R1: Opcode bits [6:0] are classified as 0x33 register-register, 0x13 immediate arithmetic, 0x03 load, 0x23 store, 0x63 branch, 0x67 register-indirect jump, 0x6F PC-relative jump, 0x17 add-upper-to-PC and 0x37 load-upper. Any other opcode drives `rf_we`, `mem_req`, `mem_we`, `pc_src`, `opa_src`, `opb_src` and `wb_src` to 0 and `alu_fn` to 0.
- R2: `pc_src` (0 = PC+4, 1 = ALU target) is 1 for both jump opcodes, equals `br_taken` for branches, and is 0 for every other opcode.
- R3: `opa_src` (0 = rs1 data, 1 = current PC) is 1 for add-upper-to-PC, the PC-relative jump and branches, and 0 otherwise.
- R4: `opb_src` (0 = rs2 data, 1 = immediate) is 0 for register-register and unrecognised opcodes and 1 for all eight other classes.
- R5: `wb_src` is 2'b01 (memory data) for loads, 2'b10 (immediate) for load-upper, 2'b11 (PC+4) for both jumps, and 2'b00 (ALU result) for all other opcodes.
- R6: `rf_we` is 0 for store, branch and unrecognised opcodes and 1 for the other seven classes.
- R7: `mem_req` is 1 exactly for loads and stores; `mem_we` is 1 exactly for stores.
- R8: For register-register instructions `alu_fn` follows funct3 (bits [14:12]): 0 gives ADD=0, or SUB=1 when bit 30 is set; 1 gives SLL=2; 2 gives SLT=3; 3 gives SLTU=4; 4 gives XOR=5; 5 gives SRL=6, or SRA=7 when bit 30 is set; 6 gives OR=8; 7 gives AND=9.
- R9: For immediate arithmetic the same funct3 mapping applies, except that bit 30 affects only funct3 = 5 (SRL/SRA). With funct3 = 0 the result is always ADD.
- R10: For load, store, branch, both jumps, add-upper-to-PC and load-upper, `alu_fn` is ADD (0) whatever funct3 and bit 30 hold.
- R11: `br_taken` has no effect on any output for non-branch opcodes.
- R12: Instruction bits other than [6:0], [14:12] and 30 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| br_taken | input | 1 | Branch comparison outcome from the datapath |
| pc_src | output | 1 | Next-PC select: 0 PC+4, 1 ALU target |
| opa_src | output | 1 | ALU operand A select: 0 rs1, 1 PC |
| opb_src | output | 1 | ALU operand B select: 0 rs2, 1 immediate |
| alu_fn | output | 4 | ALU function code |
| rf_we | output | 1 | Register file write enable |
| wb_src | output | 2 | Write-back source select |
| mem_req | output | 1 | Data memory access request |
| mem_we | output | 1 | Data memory write |

## Verification
The block has no state, so a wrong internal value is a misclassified opcode or a wrong entry in the function table. Either one shows at the ports in the same evaluation as the offending instruction word. A misclassification flips several outputs at once, such as a spurious memory write or a missing register write. A table error shows only in `alu_fn`, and only for particular funct3 and bit-30 combinations. The sweep therefore covers every opcode, funct3, bit-30 and taken combination, with the ignored bits filled with varying data.

// File: rtl/rv_ctl_pkg.sv
`timescale 1ns/1ps
package rv_ctl_pkg;

    parameter int OPC_W    = 7;
    parameter int F3_W     = 3;
    parameter int ALU_FN_W = 4;
    parameter int WB_W     = 2;

    // Major opcodes, one per instruction class
    localparam logic [OPC_W-1:0] OPC_REG    = 7'h33;
    localparam logic [OPC_W-1:0] OPC_IMM    = 7'h13;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'h03;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'h23;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;
    localparam logic [OPC_W-1:0] OPC_JREG   = 7'h67;
    localparam logic [OPC_W-1:0] OPC_JPC    = 7'h6F;
    localparam logic [OPC_W-1:0] OPC_AUPC   = 7'h17;
    localparam logic [OPC_W-1:0] OPC_LUPR   = 7'h37;

    typedef enum logic [3:0] {
        CLS_BAD    = 4'd0,
        CLS_REG    = 4'd1,
        CLS_IMM    = 4'd2,
        CLS_LOAD   = 4'd3,
        CLS_STORE  = 4'd4,
        CLS_BRANCH = 4'd5,
        CLS_JREG   = 4'd6,
        CLS_JPC    = 4'd7,
        CLS_AUPC   = 4'd8,
        CLS_LUPR   = 4'd9
    } op_class_e;

    typedef enum logic [ALU_FN_W-1:0] {
        FN_ADD  = 4'd0,
        FN_SUB  = 4'd1,
        FN_SLL  = 4'd2,
        FN_SLT  = 4'd3,
        FN_SLTU = 4'd4,
        FN_XOR  = 4'd5,
        FN_SRL  = 4'd6,
        FN_SRA  = 4'd7,
        FN_OR   = 4'd8,
        FN_AND  = 4'd9
    } alu_fn_e;

    typedef enum logic [WB_W-1:0] {
        WB_ALU  = 2'b00,
        WB_MEM  = 2'b01,
        WB_IMM  = 2'b10,
        WB_LINK = 2'b11
    } wb_sel_e;

    typedef struct packed {
        logic    pc_src;
        logic    opa_src;
        logic    opb_src;
        logic    rf_we;
        wb_sel_e wb;
        logic    mem_req;
        logic    mem_we;
    } route_t;

endpackage

// File: rtl/rv_ctl_opclass.sv
`timescale 1ns/1ps
module rv_ctl_opclass
    import rv_ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_class_e        cls
);

    always_comb begin
        case (opcode)
            OPC_REG:    cls = CLS_REG;
            OPC_IMM:    cls = CLS_IMM;
            OPC_LOAD:   cls = CLS_LOAD;
            OPC_STORE:  cls = CLS_STORE;
            OPC_BRANCH: cls = CLS_BRANCH;
            OPC_JREG:   cls = CLS_JREG;
            OPC_JPC:    cls = CLS_JPC;
            OPC_AUPC:   cls = CLS_AUPC;
            OPC_LUPR:   cls = CLS_LUPR;
            default:    cls = CLS_BAD;
        endcase
    end

endmodule

// File: rtl/rv_ctl_alu_sel.sv
`timescale 1ns/1ps
module rv_ctl_alu_sel
    import rv_ctl_pkg::*;
(
    input  op_class_e        cls,
    input  logic [F3_W-1:0]  funct3,
    input  logic             alt,
    output alu_fn_e          fn
);

    // allow_sub: bit 30 may turn an add into a subtract (register form only)
    function automatic alu_fn_e arith_fn(input logic [F3_W-1:0] f3,
                                         input logic alt_bit,
                                         input logic allow_sub);
        alu_fn_e r;
        case (f3)
            3'd0:    r = (allow_sub && alt_bit) ? FN_SUB : FN_ADD;
            3'd1:    r = FN_SLL;
            3'd2:    r = FN_SLT;
            3'd3:    r = FN_SLTU;
            3'd4:    r = FN_XOR;
            3'd5:    r = alt_bit ? FN_SRA : FN_SRL;
            3'd6:    r = FN_OR;
            default: r = FN_AND;
        endcase
        return r;
    endfunction

    always_comb begin
        case (cls)
            CLS_REG: fn = arith_fn(funct3, alt, 1'b1);
            CLS_IMM: fn = arith_fn(funct3, alt, 1'b0);
            default: fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/rv_ctl_route.sv
`timescale 1ns/1ps
module rv_ctl_route
    import rv_ctl_pkg::*;
(
    input  op_class_e cls,
    input  logic      br_taken,
    output route_t    rt
);

    always_comb begin
        rt = '{pc_src: 1'b0, opa_src: 1'b0, opb_src: 1'b0, rf_we: 1'b0,
               wb: WB_ALU, mem_req: 1'b0, mem_we: 1'b0};
        case (cls)
            CLS_REG: begin
                rt.rf_we   = 1'b1;
            end
            CLS_IMM: begin
                rt.opb_src = 1'b1;
                rt.rf_we   = 1'b1;
            end
            CLS_LOAD: begin
                rt.opb_src = 1'b1;
                rt.rf_we   = 1'b1;
                rt.wb      = WB_MEM;
                rt.mem_req = 1'b1;
            end
            CLS_STORE: begin
                rt.opb_src = 1'b1;
                rt.mem_req = 1'b1;
                rt.mem_we  = 1'b1;
            end
            CLS_BRANCH: begin
                rt.pc_src  = br_taken;
                rt.opa_src = 1'b1;
                rt.opb_src = 1'b1;
            end
            CLS_JREG: begin
                rt.pc_src  = 1'b1;
                rt.opb_src = 1'b1;
                rt.rf_we   = 1'b1;
                rt.wb      = WB_LINK;
            end
            CLS_JPC: begin
                rt.pc_src  = 1'b1;
                rt.opa_src = 1'b1;
                rt.opb_src = 1'b1;
                rt.rf_we   = 1'b1;
                rt.wb      = WB_LINK;
            end
            CLS_AUPC: begin
                rt.opa_src = 1'b1;
                rt.opb_src = 1'b1;
                rt.rf_we   = 1'b1;
            end
            CLS_LUPR: begin
                rt.opb_src = 1'b1;
                rt.rf_we   = 1'b1;
                rt.wb      = WB_IMM;
            end
            default: begin
                rt.wb      = WB_ALU;
            end
        endcase
    end

endmodule

// File: rtl/rv_ctl_decoder.sv
`timescale 1ns/1ps
module rv_ctl_decoder
    import rv_ctl_pkg::*;
#(
    parameter int ILEN    = 32,
    parameter int F3_LSB  = 12,
    parameter int ALT_BIT = 30
) (
    input  logic [ILEN-1:0]     instr,
    input  logic                br_taken,
    output logic                pc_src,
    output logic                opa_src,
    output logic                opb_src,
    output logic [ALU_FN_W-1:0] alu_fn,
    output logic                rf_we,
    output logic [WB_W-1:0]     wb_src,
    output logic                mem_req,
    output logic                mem_we
);

    localparam int F3_MSB = F3_LSB + F3_W - 1;

    op_class_e cls;
    alu_fn_e   fn;
    route_t    rt;

    logic unused_fields;
    assign unused_fields = ^{instr[ILEN-1:ALT_BIT+1], instr[ALT_BIT-1:F3_MSB+1],
                             instr[F3_LSB-1:OPC_W]};

    rv_ctl_opclass u_cls (
        .opcode (instr[OPC_W-1:0]),
        .cls    (cls)
    );

    rv_ctl_alu_sel u_alu (
        .cls    (cls),
        .funct3 (instr[F3_MSB:F3_LSB]),
        .alt    (instr[ALT_BIT]),
        .fn     (fn)
    );

    rv_ctl_route u_rt (
        .cls      (cls),
        .br_taken (br_taken),
        .rt       (rt)
    );

    assign pc_src  = rt.pc_src;
    assign opa_src = rt.opa_src;
    assign opb_src = rt.opb_src;
    assign rf_we   = rt.rf_we;
    assign wb_src  = rt.wb;
    assign mem_req = rt.mem_req;
    assign mem_we  = rt.mem_we;
    assign alu_fn  = fn;

endmodule

// File: rtl/rv_ctl_decoder_chk.sv
`timescale 1ns/1ps
module rv_ctl_decoder_chk (
    input logic [31:0] instr,
    input logic        br_taken,
    input logic        pc_src,
    input logic        opa_src,
    input logic        opb_src,
    input logic [3:0]  alu_fn,
    input logic        rf_we,
    input logic [1:0]  wb_src,
    input logic        mem_req,
    input logic        mem_we
);

    logic [6:0] op;
    logic       known;
    logic       unused_chk;
    assign op    = instr[6:0];
    assign unused_chk = ^instr[31:7];
    assign known = (op == 7'h33) || (op == 7'h13) || (op == 7'h03) ||
                   (op == 7'h23) || (op == 7'h63) || (op == 7'h67) ||
                   (op == 7'h6F) || (op == 7'h17) || (op == 7'h37);

    always_comb begin
        if (!$isunknown({instr, br_taken})) begin
            assert_store_implies_req_R7: assert (!mem_we || mem_req)
                else $error("mem_we without mem_req");
            assert_store_no_regwrite_R6: assert (!mem_we || !rf_we)
                else $error("store writes register file");
            assert_unknown_quiet_R1: assert (known || !(rf_we || mem_req || mem_we || pc_src))
                else $error("unrecognised opcode has side effects");
            assert_untaken_branch_seq_R2: assert (!(op == 7'h63 && !br_taken) || !pc_src)
                else $error("untaken branch redirects PC");
            assert_load_wb_mem_R5: assert (!(mem_req && !mem_we) || wb_src == 2'b01)
                else $error("load not writing back memory data");
            assert_pc_operand_R3: assert (!opa_src || op == 7'h17 || op == 7'h6F || op == 7'h63)
                else $error("PC operand on wrong class");
            assert_no_rs2_without_reg_R4: assert (opb_src || op == 7'h33 || !known)
                else $error("rs2 operand on immediate class");
            assert_plain_add_R10: assert (op == 7'h33 || op == 7'h13 || alu_fn == 4'd0)
                else $error("non-arith class not ADD");
        end
    end

endmodule

bind rv_ctl_decoder rv_ctl_decoder_chk u_chk (
    .instr    (instr),
    .br_taken (br_taken),
    .pc_src   (pc_src),
    .opa_src  (opa_src),
    .opb_src  (opb_src),
    .alu_fn   (alu_fn),
    .rf_we    (rf_we),
    .wb_src   (wb_src),
    .mem_req  (mem_req),
    .mem_we   (mem_we)
);

// File: tb/rv_ctl_decoder_tb.sv
`timescale 1ns/1ps
module rv_ctl_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        br_taken = 1'b0;
    logic        pc_src, opa_src, opb_src, rf_we, mem_req, mem_we;
    logic [3:0]  alu_fn;
    logic [1:0]  wb_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    rv_ctl_decoder u_dut (
        .instr(instr), .br_taken(br_taken), .pc_src(pc_src), .opa_src(opa_src),
        .opb_src(opb_src), .alu_fn(alu_fn), .rf_we(rf_we), .wb_src(wb_src),
        .mem_req(mem_req), .mem_we(mem_we)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (instr=%08h taken=%0b)",
                     req, what, act, exp, instr, br_taken);
        end
    endtask

    // Expected ALU code for the arithmetic forms, numbered per R8
    function automatic int exp_arith(input int f3, input bit b30, input bit regform);
        int base[8] = '{0, 2, 3, 4, 5, 6, 8, 9};
        int v = base[f3];
        if (f3 == 0 && regform && b30) v = 1;
        if (f3 == 5 && b30) v = 7;
        return v;
    endfunction

    task automatic check_vec(input int op, input int f3, input bit b30, input bit tk);
        bit is_r  = (op == 'h33);
        bit is_i  = (op == 'h13);
        bit is_ld = (op == 'h03);
        bit is_st = (op == 'h23);
        bit is_br = (op == 'h63);
        bit is_jr = (op == 'h67);
        bit is_jp = (op == 'h6F);
        bit is_au = (op == 'h17);
        bit is_lu = (op == 'h37);
        bit known = is_r | is_i | is_ld | is_st | is_br | is_jr | is_jp | is_au | is_lu;
        int e_pc, e_wb, e_fn;
        string rq;
        e_pc = (is_jr || is_jp) ? 1 : (is_br ? int'(tk) : 0);
        e_wb = is_ld ? 1 : (is_lu ? 2 : ((is_jr || is_jp) ? 3 : 0));
        e_fn = is_r ? exp_arith(f3, b30, 1) : (is_i ? exp_arith(f3, b30, 0) : 0);
        rq = known ? "R2" : "R1";
        if (known && !is_br && tk) rq = "R11";
        chk(rq, "pc_src", int'(pc_src), e_pc);
        chk(known ? "R3" : "R1", "opa_src", int'(opa_src), int'(is_au | is_jp | is_br));
        chk(known ? "R4" : "R1", "opb_src", int'(opb_src), int'(known & !is_r));
        chk(is_r ? "R8" : (is_i ? "R9" : "R10"), "alu_fn", int'(alu_fn), e_fn);
        chk(known ? "R6" : "R1", "rf_we", int'(rf_we), int'(known & !is_st & !is_br));
        chk(known ? "R5" : "R1", "wb_src", int'(wb_src), e_wb);
        chk(known ? "R7" : "R1", "mem_req", int'(mem_req), int'(is_ld | is_st));
        chk(known ? "R7" : "R1", "mem_we", int'(mem_we), int'(is_st));
    endtask

    function automatic logic [31:0] build(input int op, input int f3, input bit b30,
                                          input logic [31:0] fill);
        logic [31:0] w = fill;
        w[6:0]   = op[6:0];
        w[14:12] = f3[2:0];
        w[30]    = b30;
        return w;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [14:0] sig_a, sig_b;
        int reps[9] = '{'h33, 'h13, 'h03, 'h23, 'h63, 'h67, 'h6F, 'h17, 'h37};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-time condition: all-zero word is unrecognised, everything quiet (R1)
        @(negedge clk);
        chk("R1", "quiet outputs on zero word",
            int'({pc_src, opa_src, opb_src, alu_fn, rf_we, wb_src, mem_req, mem_we}), 0);

        // Exhaustive sweep: opcode x funct3 x bit30 x taken, ignored bits filled (R1..R11)
        for (int op = 0; op < 128; op++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int t = 0; t < 2; t++) begin
                        @(posedge clk);
                        instr    = build(op, f3, b[0],
                                         (op * 32'h9E3779B9) ^ (f3 * 32'h01234567) ^ 32'h5A5A5A5A);
                        br_taken = t[0];
                        @(negedge clk);
                        check_vec(op, f3, b[0], t[0]);
                    end
                end
            end
        end

        // R12: ignored bits all-zero vs all-one give identical outputs
        for (int k = 0; k < 9; k++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                @(posedge clk);
                instr = build(reps[k], f3, 1'b1, 32'h0);
                br_taken = 1'b1;
                @(negedge clk);
                sig_a = {pc_src, opa_src, opb_src, alu_fn, rf_we, wb_src, mem_req, mem_we, 2'b00};
                @(posedge clk);
                instr = build(reps[k], f3, 1'b1, 32'hFFFF_FFFF);
                @(negedge clk);
                sig_b = {pc_src, opa_src, opb_src, alu_fn, rf_we, wb_src, mem_req, mem_we, 2'b00};
                chk("R12", "outputs independent of unused bits", int'(sig_b), int'(sig_a));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule